// File: doc/BRIEF.md
# Rotate Mask Insert Shifter

This block is the rotate and shift datapath of a 32-bit fixed-point execution unit. Bits are numbered from the most significant end: position 0 is the MSB and position 31 is the LSB. A single left rotator turns the source word by a 5-bit amount. A mask generator produces a run of ones between a begin position and an end position. A final select then keeps the rotated bits where the mask is one and fills every other position from a source that depends on the operation.

That one structure covers several operations. Rotate-and-mask clears the bits outside the mask. Rotate-and-insert merges the rotated bits into a destination word. Logical shifts fill vacated bits with zero. The algebraic right shift fills them with copies of the sign. Two further shifts fill vacated bits from a 32-bit MQ word.

When the record flag is set, the block also returns a 4-bit condition field. This field compares the result with zero as a signed number. Each request presented with `in_valid` produces its result one clock later. Register-file access and instruction decode belong to the surrounding pipeline.

Top module: `rmi_shifter`

## Requirements
- R1: Rotation is to the left. With a full mask (begin 0, end 31) and op 0, the result equals the source rotated left by `sh_cnt[4:0]`. A bit leaving position 0 (the MSB) re-enters at position 31 (the LSB).
- R2: For ops 0, 1 and 7, the mask is one from position `mask_begin` through position `mask_end` inclusive. When begin is greater than end, the mask wraps: it is one from begin to 31 and from 0 to end. When begin equals end, exactly one bit is set.
- R3: Op 0 (rotate-and-mask) returns the rotated word ANDed with the mask. Op 7 is reserved and behaves as op 0.
- R4: Op 1 (rotate-and-insert) returns the rotated bit where the mask is one and the `dst` bit where the mask is zero.
- R5: Op 2 (logical left shift) and op 3 (logical right shift) use `sh_cnt` from 0 to 63 and fill vacated bits with zero. A right shift by n is performed as a left rotate by (32 - n) mod 32. A count of 32 or more returns zero. These ops ignore the mask inputs.
- R6: Op 4 (algebraic right shift) fills vacated bits with copies of source bit 0 (the MSB). A count of 32 or more returns 32 copies of the sign.
- R7: Op 5 (left shift with MQ fill) and op 6 (right shift with MQ fill) use `sh_cnt[4:0]` only. Vacated bit positions take the corresponding bits of `mq`.
- R8: With `rc` = 1, `cond_out` is {lt, gt, eq, so}, MSB first. lt, gt and eq come from a signed compare of the result with zero, and so is a copy of `so_in`. With `rc` = 0, `cond_out` is 0000.
- R9: The result and condition field appear one cycle after a request is accepted, and `out_valid` follows `in_valid` with the same one-cycle delay. A synchronous active-low reset clears `out_valid`, `result` and `cond_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation select (0..7, see requirements) |
| rc | input | 1 | Record flag: produce the condition field |
| so_in | input | 1 | Summary-overflow value copied into the condition field |
| sh_cnt | input | 6 | Rotate amount (low 5 bits) or shift count |
| mask_begin | input | 5 | First mask position (MSB-0) |
| mask_end | input | 5 | Last mask position (MSB-0) |
| src | input | 32 | Word to rotate |
| dst | input | 32 | Destination word for insert |
| mq | input | 32 | MQ fill word |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Result word |
| cond_out | output | 4 | Condition field {lt, gt, eq, so} |

## Verification
Two sources isolate rotation direction and wrap-around through every one of the 32 amounts: a word with only its end bits set, and random words. Non-wrapping, wrapping and single-bit masks exercise the begin/end decode, and distinct random `dst` words show which positions insert keeps. Shift counts are swept from 0 to 40 with positive and negative sources, which separates zero fill from sign fill and checks the clamp at 32 and above. The MQ shifts use a fill pattern unlike the source. Results that are zero, negative and positive, each with both `so_in` values and with `rc` cleared, check the condition field.

// File: rtl/rmi_pkg.sv
// Shared definitions for the rotate/mask/insert shifter.
// Assumes a data width that is a power of two.
package rmi_pkg;
    typedef enum logic [2:0] {
        OP_ROT_AND = 3'd0,
        OP_ROT_INS = 3'd1,
        OP_SHL     = 3'd2,
        OP_SHR     = 3'd3,
        OP_SRA     = 3'd4,
        OP_SHL_MQ  = 3'd5,
        OP_SHR_MQ  = 3'd6,
        OP_RSVD    = 3'd7
    } rmi_op_e;

    localparam int COND_W = 4;
endpackage

// File: rtl/rmi_rotator.sv
// Logarithmic left rotator. A bit leaving the MSB (position 0 in MSB-0
// numbering) re-enters at the LSB. Assumes W is a power of two.
module rmi_rotator #(
    parameter int W  = 32,
    parameter int LW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [LW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [0:LW];

    assign stage[0] = din;

    // One stage per amount bit, each rotating by a power of two.
    for (genvar s = 0; s < LW; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign stage[s+1] = amt[s] ? {stage[s][W-1-SH:0], stage[s][W-1:W-SH]}
                                   : stage[s];
    end

    assign dout = stage[LW];

    // Rotation moves bits around and never creates or drops any (R1).
    always_comb begin
        if (!$isunknown(din) && !$isunknown(amt))
            a_r1_rot_keeps_ones: assert ($countones(dout) == $countones(din));
    end
endmodule

// File: rtl/rmi_mask_gen.sv
// Builds a mask from begin to end positions (MSB-0, inclusive).
// The run wraps past position W-1 when begin > end. Assumes W is a power of two.
module rmi_mask_gen #(
    parameter int W  = 32,
    parameter int LW = $clog2(W)
) (
    input  logic [LW-1:0] mb,
    input  logic [LW-1:0] me,
    output logic [W-1:0]  mask
);
    logic [LW-1:0] span;

    // Length of the run minus one, modulo W.
    assign span = me - mb;

    // A position is inside the run when its distance from begin is within the span.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [LW-1:0] off;
        assign off = LW'(i) - mb;
        assign mask[W-1-i] = (off <= span);
    end

    // Number of ones matches the inclusive run length, wrapped or not (R2).
    always_comb begin
        if (!$isunknown(mb) && !$isunknown(me))
            a_r2_mask_run_len: assert ($countones(mask) ==
                ((mb <= me) ? (int'(me) - int'(mb) + 1) : (W - int'(mb) + int'(me) + 1)));
    end
endmodule

// File: rtl/rmi_cond.sv
// Condition field from a signed compare of the result with zero.
// The overflow summary bit is passed through. The field is zero when recording is off.
module rmi_cond #(
    parameter int W = 32
) (
    input  logic [W-1:0]                  res,
    input  logic                          rc,
    input  logic                          so_in,
    output logic [rmi_pkg::COND_W-1:0]    cond
);
    logic is_neg, is_zero;

    // Sign and zero detection on the result.
    always_comb begin
        is_neg  = res[W-1];
        is_zero = (res == '0);
        cond    = rc ? {is_neg, !is_neg && !is_zero, is_zero, so_in} : '0;
    end
endmodule

// File: rtl/rmi_shifter.sv
// Top of the rotate/mask/insert shifter. It decodes the operation into a
// rotate amount, mask bounds and a fill word, then registers the merged result
// and condition field. Latency is one cycle. Reset is synchronous and active low.
module rmi_shifter #(
    parameter int W  = 32,
    parameter int LW = $clog2(W)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [2:0]                    op,
    input  logic                          rc,
    input  logic                          so_in,
    input  logic [LW:0]                   sh_cnt,
    input  logic [LW-1:0]                 mask_begin,
    input  logic [LW-1:0]                 mask_end,
    input  logic [W-1:0]                  src,
    input  logic [W-1:0]                  dst,
    input  logic [W-1:0]                  mq,
    output logic                          out_valid,
    output logic [W-1:0]                  result,
    output logic [rmi_pkg::COND_W-1:0]    cond_out
);
    import rmi_pkg::*;

    rmi_op_e          op_c;
    logic [LW-1:0]    cnt_lo, rot_amt, mb_eff, me_eff;
    logic             over_range;
    logic             kill_mask;
    logic [W-1:0]     fill_word, rot_word, mask_raw, mask_eff, merged;
    logic [COND_W-1:0] cond_c;

    assign op_c       = rmi_op_e'(op);
    assign cnt_lo     = sh_cnt[LW-1:0];
    assign over_range = sh_cnt[LW];

    // Operation decode: rotate amount, mask bounds, fill source, range clamp.
    always_comb begin
        rot_amt   = cnt_lo;
        mb_eff    = mask_begin;
        me_eff    = mask_end;
        fill_word = '0;
        kill_mask = 1'b0;
        case (op_c)
            OP_ROT_INS: fill_word = dst;
            OP_SHL: begin
                mb_eff    = '0;
                me_eff    = LW'(W-1) - cnt_lo;
                kill_mask = over_range;
            end
            OP_SHR: begin
                rot_amt   = -cnt_lo;
                mb_eff    = cnt_lo;
                me_eff    = LW'(W-1);
                kill_mask = over_range;
            end
            OP_SRA: begin
                rot_amt   = -cnt_lo;
                mb_eff    = cnt_lo;
                me_eff    = LW'(W-1);
                kill_mask = over_range;
                fill_word = {W{src[W-1]}};
            end
            OP_SHL_MQ: begin
                mb_eff    = '0;
                me_eff    = LW'(W-1) - cnt_lo;
                fill_word = mq;
            end
            OP_SHR_MQ: begin
                rot_amt   = -cnt_lo;
                mb_eff    = cnt_lo;
                me_eff    = LW'(W-1);
                fill_word = mq;
            end
            default: fill_word = '0;
        endcase
    end

    rmi_rotator #(.W(W), .LW(LW)) u_rot (
        .din  (src),
        .amt  (rot_amt),
        .dout (rot_word)
    );

    rmi_mask_gen #(.W(W), .LW(LW)) u_mask (
        .mb   (mb_eff),
        .me   (me_eff),
        .mask (mask_raw)
    );

    // Merge rotated bits and fill under the mask; an out-of-range shift empties the mask.
    always_comb begin
        mask_eff = kill_mask ? '0 : mask_raw;
        merged   = (rot_word & mask_eff) | (fill_word & ~mask_eff);
    end

    rmi_cond #(.W(W)) u_cond (
        .res   (merged),
        .rc    (rc),
        .so_in (so_in),
        .cond  (cond_c)
    );

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            cond_out  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result   <= merged;
                cond_out <= cond_c;
            end
        end
    end

    // R9: valid tracks the request one cycle later.
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5: a logical shift by W or more yields zero.
    a_r5_big_shift_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 3'd2 || op == 3'd3) && sh_cnt[LW]) |=> (result == '0));

    // R6: an algebraic shift by W or more yields all sign copies.
    a_r6_big_sra_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd4 && sh_cnt[LW]) |=> (result == {W{$past(src[W-1])}}));

    // R8: at most one of lt/gt/eq, and eq only with a zero result.
    a_r8_cond_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0(cond_out[3:1]));
    a_r8_eq_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cond_out[1]) |-> (result == '0));
endmodule

// File: tb/sim_rmi_shifter.sv
// Scoreboard bench: the driver pushes model results, the monitor pops and compares them.
module sim_rmi_shifter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, rc, so_in;
    logic [2:0]  op;
    logic [5:0]  sh_cnt;
    logic [4:0]  mask_begin, mask_end;
    logic [31:0] src, dst, mq;
    logic        out_valid;
    logic [31:0] result;
    logic [3:0]  cond_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] res;
        logic [3:0]  cr;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;   // 50 MHz

    rmi_shifter u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .rc(rc),
        .so_in(so_in), .sh_cnt(sh_cnt), .mask_begin(mask_begin),
        .mask_end(mask_end), .src(src), .dst(dst), .mq(mq),
        .out_valid(out_valid), .result(result), .cond_out(cond_out)
    );

    // Behavioural model, written bit by bit in MSB-0 numbering.
    function automatic exp_t model(input logic [2:0] o, input logic [5:0] c,
                                   input logic [4:0] b, input logic [4:0] e,
                                   input logic [31:0] s, input logic [31:0] d,
                                   input logic [31:0] q, input logic r,
                                   input logic so, input string tag);
        exp_t x;
        int n, rot;
        bit kill, m;
        logic [31:0] fill, res;
        n = int'(c[4:0]);
        kill = 0;
        fill = '0;
        rot = n;
        case (o)
            3'd1: fill = d;
            3'd2: kill = c[5];
            3'd3: begin rot = (32 - n) % 32; kill = c[5]; end
            3'd4: begin rot = (32 - n) % 32; kill = c[5]; fill = {32{s[31]}}; end
            3'd5: fill = q;
            3'd6: begin rot = (32 - n) % 32; fill = q; end
            default: fill = '0;
        endcase
        for (int i = 0; i < 32; i++) begin
            case (o)
                3'd2, 3'd5:       m = (i <= 31 - n);
                3'd3, 3'd4, 3'd6: m = (i >= n);
                default:          m = (b <= e) ? (i >= b && i <= e) : (i >= b || i <= e);
            endcase
            if (kill) m = 0;
            res[31-i] = m ? s[31 - ((i + rot) % 32)] : fill[31-i];
        end
        x.res = res;
        x.cr  = r ? {res[31], !res[31] && res != 0, res == 0, so} : 4'b0000;
        x.tag = tag;
        return x;
    endfunction

    task automatic send(input logic [2:0] o, input logic [5:0] c,
                        input logic [4:0] b, input logic [4:0] e,
                        input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] q, input logic r, input logic so,
                        input string tag);
        @(negedge clk);
        in_valid = 1'b1; op = o; sh_cnt = c; mask_begin = b; mask_end = e;
        src = s; dst = d; mq = q; rc = r; so_in = so;
        sb.push_back(model(o, c, b, e, s, d, q, r, so, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare each valid output with the oldest expected item.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n === 1'b1 && out_valid === 1'b1) begin
                n_checks++;
                if (sb.size() == 0) begin
                    n_fail++;
                    $display("FAIL R9 unexpected output: got %h/%b, expected none", result, cond_out);
                end else begin
                    exp_t x;
                    x = sb.pop_front();
                    if (result !== x.res || cond_out !== x.cr) begin
                        n_fail++;
                        $display("FAIL %s: got %h cr=%b, expected %h cr=%b",
                                 x.tag, result, cond_out, x.res, x.cr);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; op = '0; rc = 0; so_in = 0; sh_cnt = '0;
        mask_begin = '0; mask_end = '0; src = '0; dst = '0; mq = '0;
        repeat (3) @(posedge clk);
        #5;
        // R9: reset state.
        n_checks++;
        if (out_valid !== 1'b0 || result !== 32'h0 || cond_out !== 4'h0) begin
            n_fail++;
            $display("FAIL R9 reset: got v=%b r=%h c=%b, expected 0/0/0", out_valid, result, cond_out);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every rotate amount with a full mask.
        for (int a = 0; a < 32; a++) begin
            send(3'd0, 6'(a), 5'd0, 5'd31, 32'h8000_0001, '0, '0, 0, 0, "R1");
            send(3'd0, 6'(a), 5'd0, 5'd31, $urandom, '0, '0, 0, 0, "R1");
        end

        // R2/R3: plain, wrapped and single-bit masks with AND; reserved op 7.
        for (int k = 0; k < 40; k++) begin
            logic [4:0] b, e;
            b = 5'($urandom); e = 5'($urandom);
            send(3'd0, 6'($urandom), b, e, $urandom, '0, '0, 0, 0, "R2");
            send(3'd0, 6'($urandom), 5'd28, 5'd3, $urandom, '0, '0, 0, 0, "R2");
            send(3'd0, 6'($urandom), b, b, 32'hFFFF_FFFF, '0, '0, 0, 0, "R2");
            send(3'd7, 6'($urandom), b, e, $urandom, '0, '0, 0, 0, "R3");
        end

        // R4: insert under plain and wrapped masks.
        for (int k = 0; k < 40; k++) begin
            send(3'd1, 6'($urandom), 5'($urandom), 5'($urandom), $urandom, $urandom, '0, 0, 0, "R4");
            send(3'd1, 6'(k % 32), 5'd30, 5'd1, $urandom, $urandom, '0, 0, 0, "R4");
        end

        // R5/R6: logical and algebraic shifts, counts 0..40 and 63.
        for (int c = 0; c <= 41; c++) begin
            logic [5:0] cc;
            cc = (c == 41) ? 6'd63 : 6'(c);
            send(3'd2, cc, 5'($urandom), 5'($urandom), 32'hC3A5_5A3C, '0, '0, 0, 0, "R5");
            send(3'd3, cc, 5'($urandom), 5'($urandom), 32'hC3A5_5A3C, '0, '0, 0, 0, "R5");
            send(3'd4, cc, 5'd0, 5'd0, 32'h9234_5678, '0, '0, 0, 0, "R6");
            send(3'd4, cc, 5'd0, 5'd0, 32'h7234_5678, '0, '0, 0, 0, "R6");
        end

        // R7: MQ-fill shifts, including a set bit 5 that must be ignored.
        for (int c = 0; c < 32; c++) begin
            send(3'd5, 6'(c), 5'd0, 5'd0, 32'hF0F0_1234, '0, 32'h0F0F_A5A5, 0, 0, "R7");
            send(3'd6, 6'(c) | 6'h20, 5'd0, 5'd0, 32'hF0F0_1234, '0, 32'h0F0F_A5A5, 0, 0, "R7");
        end

        // R8: record with zero, negative and positive results, so toggled, and rc off.
        for (int s = 0; s < 2; s++) begin
            send(3'd0, 6'd0, 5'd0, 5'd31, 32'h0, '0, '0, 1, s[0], "R8");
            send(3'd0, 6'd0, 5'd0, 5'd31, 32'h8000_0000, '0, '0, 1, s[0], "R8");
            send(3'd0, 6'd4, 5'd0, 5'd31, 32'h0000_0010, '0, '0, 1, s[0], "R8");
            send(3'd4, 6'd40, 5'd0, 5'd0, 32'h8000_0000, '0, '0, 1, s[0], "R8");
            send(3'd0, 6'd4, 5'd0, 5'd31, 32'h8000_0010, '0, '0, 0, 1, "R8");
        end

        // R9: a bubble produces no output.
        idle();
        @(posedge clk);
        @(posedge clk);
        #5;
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 bubble: got out_valid=%b, expected 0", out_valid);
        end
        send(3'd1, 6'd8, 5'd8, 5'd15, 32'h00AB_0000, 32'h1111_1111, '0, 1, 0, "R9");
        idle();
        repeat (4) @(posedge clk);
        #5;
        n_checks++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R9 drain: got %0d pending, expected 0", sb.size());
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule